// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept, judging only by its 48-bit destination address. It holds sixteen programmable station addresses, one enable bit for each, and a five-bit command word. The command word can accept whole classes of frames (unicast, multicast, broadcast), turn on address matching against the table, and invert the sense of that match.

The receive path presents the destination address one byte per cycle, with the first byte marked by a frame-start strobe. One cycle after the sixth byte, the block raises a one-cycle valid pulse together with its accept or reject decision. A 32-bit write port loads the table, the enable mask and the command word.

The configuration is copied into a working bank when a frame starts. A write made while a frame is in progress therefore only affects the following frame.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset every entry is disabled, the command word is zero, `verdict_vld` is low, and every frame is rejected whatever its address.
- R2: Entry k has its high word at byte offset 8*k and its low word at 8*k+4. The high word holds address byte 0 in bits 31:24 down to byte 3 in bits 7:0. The low word holds byte 4 in bits 31:24 and byte 5 in bits 23:16, and its bits 15:0 are ignored. Byte 0 is the first byte received.
- R3: The enable mask sits at offset 0x80, with bit k enabling entry k. A disabled entry never matches.
- R4: The command word sits at offset 0x84. When its bit 4 is set, a frame whose address equals an enabled entry is accepted.
- R5: When bits 4 and 3 are both set, the match sense is inverted: a frame that matches no enabled entry is accepted and a matching one is not. Bit 3 alone accepts nothing.
- R6: Command bit 0 accepts every unicast frame. A frame is unicast when bit 0 of byte 0 is 0.
- R7: Command bit 1 accepts every multicast frame. A frame is multicast when bit 0 of byte 0 is 1 and the address is not all ones.
- R8: Command bit 2 accepts the broadcast address (all 48 bits set). A broadcast frame is not treated as multicast.
- R9: A frame begins with `frm_start` and `rx_vld` high together. Only cycles with `rx_vld` high carry a byte, so idle gaps are allowed. `verdict_vld` pulses for exactly one cycle, in the cycle after the sixth byte is taken. Further bytes, and bytes sent without a frame start, produce no verdict.
- R10: A write that lands in any cycle of a frame, including the start cycle, is not seen by that frame's verdict. It applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Byte offset of the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| frm_start | input | 1 | Marks the first destination byte of a frame |
| rx_vld | input | 1 | `rx_byte` carries a byte this cycle |
| rx_byte | input | 8 | Destination address byte |
| verdict_vld | output | 1 | One-cycle pulse: decision is valid |
| verdict_accept | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
Several properties are checked on every cycle:
- an accept is never raised without a valid pulse;
- the valid pulse never lasts two cycles;
- a zero command word never yields an accept;
- the working enable mask and command word stay fixed while a frame is being collected;
- a table hit never occurs with an empty enable mask.

Other behaviour can only be shown by the bench's scenarios:
- the byte packing of the table words;
- the decode of each command bit;
- the inversion of the match sense;
- the unicast, multicast and broadcast classification;
- the rule that mid-frame writes apply to the next frame.

These are covered by directed frames and by randomized traffic compared against a reference model.

// File: rtl/filt_pkg.sv
package filt_pkg;
  localparam int MAC_W      = 48;
  localparam int ADDR_BYTES = MAC_W / 8;
  localparam int CMD_W      = 5;
  localparam int CMD_UNI    = 0;
  localparam int CMD_MULTI  = 1;
  localparam int CMD_BCAST  = 2;
  localparam int CMD_INVERT = 3;
  localparam int CMD_MATCH  = 4;
  localparam int GROUP_BIT  = MAC_W - 8;
  typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/filt_regfile.sv
module filt_regfile
  import filt_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  input  logic              load,
  output mac_t              act_tbl [N_ENT],
  output logic [N_ENT-1:0]  act_en,
  output logic [CMD_W-1:0]  act_cmd
);
  localparam int WW       = AW - 2;
  localparam int EN_WORD  = 2 * N_ENT;
  localparam int CMD_WORD = 2 * N_ENT + 1;

  logic [WW-1:0]    widx;
  logic [N_ENT-1:0] hi_we, lo_we;
  logic             en_we, cmd_we;
  logic [31:0]      p_hi [N_ENT];
  logic [15:0]      p_lo [N_ENT];
  logic [N_ENT-1:0] p_en_q, p_en_d, act_en_d;
  logic [CMD_W-1:0] p_cmd_q, p_cmd_d, act_cmd_d;

  assign widx   = addr[AW-1:2];
  assign en_we  = we && (widx == WW'(EN_WORD));
  assign cmd_we = we && (widx == WW'(CMD_WORD));

  always_comb begin
    for (int k = 0; k < N_ENT; k++) begin
      hi_we[k] = we && (widx == WW'(2 * k));
      lo_we[k] = we && (widx == WW'(2 * k + 1));
    end
  end

  // table storage: no reset, entries only matter once enabled
  always_ff @(posedge clk) begin
    for (int k = 0; k < N_ENT; k++) begin
      if (hi_we[k]) p_hi[k] <= wdata;
      if (lo_we[k]) p_lo[k] <= wdata[31:16];
      if (load)     act_tbl[k] <= {p_hi[k], p_lo[k]};
    end
  end

  always_comb begin
    p_en_d    = en_we  ? wdata[N_ENT-1:0] : p_en_q;
    p_cmd_d   = cmd_we ? wdata[CMD_W-1:0] : p_cmd_q;
    act_en_d  = load   ? p_en_q  : act_en;
    act_cmd_d = load   ? p_cmd_q : act_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_en_q  <= '0;
      p_cmd_q <= '0;
      act_en  <= '0;
      act_cmd <= '0;
    end else begin
      p_en_q  <= p_en_d;
      p_cmd_q <= p_cmd_d;
      act_en  <= act_en_d;
      act_cmd <= act_cmd_d;
    end
  end
endmodule

// File: rtl/filt_addr_collect.sv
module filt_addr_collect
  import filt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       vld,
  input  logic [7:0] data,
  output mac_t       key,
  output logic       last,
  output logic       busy
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam int SW = (ADDR_BYTES - 1) * 8;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sh_q, sh_d;
  logic          sh_en;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = {sh_q[SW-9:0], data};
    sh_en = 1'b0;
    last  = 1'b0;
    if (vld && start) begin
      cnt_d = CW'(1);
      sh_en = 1'b1;
    end else if (vld && cnt_q != '0 && cnt_q < CW'(ADDR_BYTES)) begin
      cnt_d = cnt_q + CW'(1);
      sh_en = 1'b1;
      last  = (cnt_q == CW'(ADDR_BYTES - 1));
    end
  end

  assign key  = {sh_q, data};
  assign busy = (cnt_q != '0) && (cnt_q < CW'(ADDR_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (sh_en) sh_q <= sh_d;
  end
endmodule

// File: rtl/filt_cam_match.sv
module filt_cam_match
  import filt_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mac_t             tbl [N_ENT],
  input  logic [N_ENT-1:0] en,
  input  mac_t             key,
  output logic             hit
);
  logic [N_ENT-1:0] m;

  for (genvar k = 0; k < N_ENT; k++) begin : g_cmp
    assign m[k] = en[k] && (tbl[k] == key);
  end

  assign hit = |m;

  // R3
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (en != '0));
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import filt_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          frm_start,
  input  logic          rx_vld,
  input  logic [7:0]    rx_byte,
  output logic          verdict_vld,
  output logic          verdict_accept
);
  logic             rs_meta, rst_sync_n;
  mac_t             act_tbl [N_ENT];
  logic [N_ENT-1:0] act_en;
  logic [CMD_W-1:0] act_cmd;
  mac_t             key;
  logic             last, busy, hit, load;
  logic             is_bc, is_mc, is_uc, accept_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta    <= 1'b1;
      rst_sync_n <= rs_meta;
    end
  end

  assign load = frm_start && rx_vld;

  filt_regfile #(.N_ENT(N_ENT), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .load(load), .act_tbl(act_tbl),
    .act_en(act_en), .act_cmd(act_cmd)
  );

  filt_addr_collect u_collect (
    .clk(clk), .rst_n(rst_sync_n), .start(frm_start), .vld(rx_vld),
    .data(rx_byte), .key(key), .last(last), .busy(busy)
  );

  filt_cam_match #(.N_ENT(N_ENT)) u_cam (
    .clk(clk), .rst_n(rst_sync_n), .tbl(act_tbl), .en(act_en),
    .key(key), .hit(hit)
  );

  always_comb begin
    is_bc    = &key;
    is_mc    = key[GROUP_BIT] && !is_bc;
    is_uc    = !key[GROUP_BIT];
    accept_d = (is_bc && act_cmd[CMD_BCAST])
             | (is_mc && act_cmd[CMD_MULTI])
             | (is_uc && act_cmd[CMD_UNI])
             | (act_cmd[CMD_MATCH] && (hit ^ act_cmd[CMD_INVERT]));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      verdict_vld    <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_vld    <= last;
      verdict_accept <= last && accept_d;
    end
  end

  // R9
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    verdict_accept |-> verdict_vld);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    verdict_vld |=> !verdict_vld);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !load) |=> ($stable(act_en) && $stable(act_cmd)));

  // R1
  zero_cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (verdict_vld && $past(act_cmd) == '0) |-> !verdict_accept);
endmodule

// File: tb/dest_addr_filter_test.sv
module dest_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        frm_start, rx_vld;
  logic [7:0]  rx_byte;
  logic        verdict_vld, verdict_accept;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  logic [47:0] m_ent [16];
  logic [15:0] m_en;
  logic [4:0]  m_cmd;
  logic [47:0] s_ent [16];
  logic [15:0] s_en;
  logic [4:0]  s_cmd;

  dest_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_start(frm_start), .rx_vld(rx_vld),
    .rx_byte(rx_byte), .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model of the write decode (R2, R3, R4)
  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int w = int'(a[7:2]);
    if (w < 32) begin
      if (w[0] == 1'b0) m_ent[w/2][47:16] = d;
      else              m_ent[w/2][15:0]  = d[31:16];
    end else if (w == 32) m_en  = d[15:0];
    else if (w == 33)     m_cmd = d[4:0];
  endtask

  function automatic logic ref_verdict(input logic [47:0] a);
    logic hit = 1'b0;
    logic bc, mc, uc;
    for (int k = 0; k < 16; k++)
      if (s_en[k] && s_ent[k] == a) hit = 1'b1;
    bc = &a;
    mc = a[40] && !bc;
    uc = !a[40];
    return (bc && s_cmd[2]) || (mc && s_cmd[1]) || (uc && s_cmd[0]) ||
           (s_cmd[4] && (hit ^ s_cmd[3]));
  endfunction

  task automatic idle();
    @(negedge clk);
    cfg_we = 1'b0; frm_start = 1'b0; rx_vld = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    frm_start = 1'b0; rx_vld = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    model_write(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_entry(input int k, input logic [47:0] mac, input logic [15:0] junk);
    wr(8'(8 * k), mac[47:16]);
    wr(8'(8 * k + 4), {mac[15:0], junk});
  endtask

  // wi: byte index carrying a config write (-1 none); gaps: max idle cycles between bytes
  task automatic send_frame(input logic [47:0] a, input int wi, input logic [7:0] wa,
                            input logic [31:0] wd, input int gaps, input string req);
    logic exp;
    for (int k = 0; k < 16; k++) s_ent[k] = m_ent[k];
    s_en = m_en; s_cmd = m_cmd;
    exp = ref_verdict(a);
    for (int i = 0; i < 6; i++) begin
      if (i > 0 && gaps > 0) begin
        int n = int'($urandom_range(gaps, 0));
        for (int g = 0; g < n; g++) idle();
      end
      @(negedge clk);
      frm_start = (i == 0);
      rx_vld    = 1'b1;
      rx_byte   = a[47 - 8 * i -: 8];
      cfg_we    = (i == wi);
      if (i == wi) begin
        cfg_addr = wa; cfg_wdata = wd;
        model_write(wa, wd);
      end
      if (i > 0) check({req, " no early verdict"}, 32'(verdict_vld), 32'd0);
    end
    @(negedge clk);
    cfg_we = 1'b0; frm_start = 1'b0; rx_vld = 1'b0;
    check({req, " R9 valid"}, 32'(verdict_vld), 32'd1);
    check({req, " accept"}, 32'(verdict_accept), 32'(exp));
    @(negedge clk);
    check({req, " R9 one-cycle"}, 32'(verdict_vld), 32'd0);
  endtask

  localparam logic [47:0] STA  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC   = 48'h01_00_5E_00_00_FB;
  localparam logic [47:0] UC   = 48'h00_1B_44_11_3A_B7;

  initial begin
    void'($urandom(32'd7321));
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; frm_start = 0; rx_vld = 0; rx_byte = 0;
    for (int k = 0; k < 16; k++) m_ent[k] = '0;
    m_en = '0; m_cmd = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 verdict_vld after reset", 32'(verdict_vld), 32'd0);
    check("R1 verdict_accept after reset", 32'(verdict_accept), 32'd0);
    send_frame(BC, -1, 0, 0, 0, "R1 broadcast");
    send_frame(MC, -1, 0, 0, 0, "R1 multicast");
    send_frame(UC, -1, 0, 0, 0, "R1 unicast");

    // R2 / R4 table packing and match
    set_entry(3, STA, 16'hBEEF);
    set_entry(0, UC ^ 48'h1, 16'h0000);
    wr(8'h80, 32'h0000_0008);
    wr(8'h84, 32'h0000_0010);
    send_frame(STA, -1, 0, 0, 0, "R2 R4 hit entry 3");
    send_frame(STA ^ 48'h00_00_00_00_00_01, -1, 0, 0, 0, "R2 byte5 differs");
    send_frame(STA ^ 48'h80_00_00_00_00_00, -1, 0, 0, 0, "R2 byte0 differs");
    send_frame(STA, -1, 0, 0, 2, "R9 R4 hit with gaps");

    // R3 enables
    wr(8'h80, 32'h0000_0001);
    send_frame(STA, -1, 0, 0, 0, "R3 entry 3 disabled");
    wr(8'h80, 32'hFFFF_0000);
    send_frame(STA, -1, 0, 0, 0, "R3 upper bits no effect");
    wr(8'h80, 32'h0000_0008);

    // R5 invert
    wr(8'h84, 32'h0000_0018);
    send_frame(STA, -1, 0, 0, 0, "R5 inverted hit");
    send_frame(UC, -1, 0, 0, 0, "R5 inverted miss");
    wr(8'h84, 32'h0000_0008);
    send_frame(UC, -1, 0, 0, 0, "R5 invert without match enable");

    // R6 R7 R8 class acceptance
    wr(8'h84, 32'h0000_0001);
    send_frame(UC, -1, 0, 0, 0, "R6 unicast");
    send_frame(MC, -1, 0, 0, 0, "R6 multicast rejected");
    wr(8'h84, 32'h0000_0002);
    send_frame(MC, -1, 0, 0, 0, "R7 multicast");
    send_frame(BC, -1, 0, 0, 0, "R8 broadcast not multicast");
    send_frame(UC, -1, 0, 0, 0, "R7 unicast rejected");
    wr(8'h84, 32'h0000_0004);
    send_frame(BC, -1, 0, 0, 0, "R8 broadcast");
    send_frame(BC ^ 48'h1, -1, 0, 0, 0, "R8 near-broadcast");

    // R9 extra bytes and bytes without start
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rx_vld = 1'b1; rx_byte = 8'($urandom);
      check("R9 trailing byte no verdict", 32'(verdict_vld), 32'd0);
    end
    idle();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rx_vld = 1'b1; rx_byte = 8'hFF;
      check("R9 no start no verdict", 32'(verdict_vld), 32'd0);
    end
    idle();

    // R10 writes during a frame
    wr(8'h84, 32'h0000_0000);
    send_frame(BC, 3, 8'h84, 32'h0000_0004, 0, "R10 mid-frame cmd write");
    send_frame(BC, -1, 0, 0, 0, "R10 next frame sees write");
    send_frame(BC, 0, 8'h84, 32'h0000_0000, 0, "R10 write on start cycle");
    send_frame(BC, -1, 0, 0, 0, "R10 next frame rejects");
    wr(8'h84, 32'h0000_0010);
    send_frame(STA, 5, 8'h1C, 32'h0, 0, "R10 entry write on last byte");
    send_frame(STA, -1, 0, 0, 0, "R10 entry change applied");

    // randomized traffic
    for (int f = 0; f < 400; f++) begin
      logic [47:0] a;
      int sel;
      int wi = -1;
      logic [7:0] wa = 0;
      logic [31:0] wd = 0;
      if (f % 25 == 0) begin
        for (int k = 0; k < 16; k++)
          set_entry(k, {$urandom, 16'($urandom)}, 16'($urandom));
        wr(8'h80, $urandom);
        wr(8'h84, $urandom);
      end
      sel = int'($urandom_range(7, 0));
      if (sel < 3)       a = m_ent[$urandom_range(15, 0)];
      else if (sel == 3) a = BC;
      else               a = {$urandom, 16'($urandom)};
      if ($urandom_range(7, 0) == 0) begin
        wi = int'($urandom_range(5, 0));
        wa = ($urandom_range(1, 0) == 1) ? 8'h84 : 8'h80;
        wd = $urandom;
      end
      send_frame(a, wi, wa, wd, int'($urandom_range(2, 0)), "R2 R3 R6 R7 R8 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule